// File: doc/BRIEF.md
# Edge-Selectable Up-Counter

This block is a small up-counter for logic clocked by one free-running system clock. Two slow control inputs, a count pulse and a count enable, are sampled by that clock. Either input can act as the counting edge. A rising pulse while enable is high advances the count. A falling enable while the pulse is low also advances it. A master clear input forces the count to zero.

The counting base is a parameter: modulo 16 (binary) or modulo 10 (decimal). All state bits are produced by one register, so they always change together.

Two instances chain into a wider counter. Tie the next stage's pulse input low and drive its enable from this stage's top bit. The next stage then steps each time that bit falls.

There is no data stream in or out, so every pin is a plain level signal with no valid/ready handshake. Each input passes through a two-flop synchronizer. A counting edge is seen as a change between two consecutive sampled values. The count register updates on the third rising clock edge after the input changes.

Top module: `edge_sel_counter`

## Requirements
- R1: A rising edge of the pulse input increments the count by one when the enable input was high before that edge.
- R2: A falling edge of the enable input increments the count by one when the pulse input was low before that edge.
- R3: These stimuli leave the count unchanged: a falling pulse edge, a rising enable edge, a rising pulse edge while enable is low, and a falling enable edge while the pulse is high.
- R4: While the pulse and enable inputs hold steady, the count does not change.
- R5: While master clear is high, the count is 0 and every counting edge is ignored. Releasing master clear does not produce a count.
- R6: With the binary base, the count runs 0 through 15 and the next increment after 15 gives 0.
- R7: With the decimal base, the count runs 0 through 9, never exceeds 9, and the next increment after 9 gives 0.
- R8: A qualifying pulse edge and a qualifying enable edge seen in the same sampled cycle increment the count only once.
- R9: Two binary instances chained through top bit to enable, with the second stage's pulse held low, form an 8-bit count {stage2, stage1}. That count reaches 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| mclr | input | 1 | Master clear, active high, asynchronous to clk |
| cnt_pulse | input | 1 | Count pulse; rising edge counts while enable is high |
| cnt_en | input | 1 | Count enable; falling edge counts while the pulse is low |
| count | output | 4 | Counter state, bit 3 is the top bit used for chaining |

## Verification
The bench builds the top with the binary base for a primary instance and a chained second stage, plus a third instance with the decimal base. The small 4-bit state lets every value and both wrap points be swept for each base. The chained pair brings the full 8-bit cycle through 255 and back to 0 within reach.

// File: rtl/edge_cnt_pkg.sv
package edge_cnt_pkg;

  typedef enum logic {
    BASE_BIN = 1'b0,
    BASE_DEC = 1'b1
  } count_base_e;

  localparam int unsigned CNT_W = 4;

  function automatic int unsigned base_modulus(count_base_e b);
    return (b == BASE_DEC) ? 10 : 16;
  endfunction

endpackage

// File: rtl/ecnt_sync.sv
module ecnt_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) chain[gi] <= chain[gi-1];
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ecnt_edge_qual.sv
module ecnt_edge_qual (
  input  logic clk,
  input  logic rst,
  input  logic pulse_s,
  input  logic en_s,
  output logic step
);

  logic pulse_d;
  logic en_d;
  logic pulse_up;
  logic en_down;

  // Previous samples follow the inputs even during clear, so the
  // release of clear never looks like an edge.
  always_ff @(posedge clk) begin
    pulse_d <= pulse_s;
    en_d    <= en_s;
  end

  // Each edge is qualified by the other input's value before the edge,
  // so simultaneous qualifying edges are both recognised.
  always_comb begin
    pulse_up = pulse_s & ~pulse_d & en_d;
    en_down  = ~en_s & en_d & ~pulse_d;
    step     = pulse_up | en_down;
  end

  AST_STEP_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    step |-> (pulse_s != $past(pulse_s)) || (en_s != $past(en_s))); // R4

  AST_NO_STEP_ON_PULSE_FALL: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_s) && $stable(en_s)) |-> !step); // R3

  AST_NO_STEP_ON_EN_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(en_s) && $stable(pulse_s)) |-> !step); // R3

endmodule

// File: rtl/ecnt_core.sv
module ecnt_core
  import edge_cnt_pkg::*;
#(
  parameter count_base_e BASE = BASE_BIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned MOD = base_modulus(BASE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  generate
    if (MOD == (1 << CNT_W)) begin : g_pow2
      assign cnt_inc = cnt_q + 1'b1;
    end else begin : g_wrap
      assign cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_inc;
  end

  assign count = cnt_q;

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= LAST); // R7

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count)); // R4

  AST_ADVANCE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> count != $past(count)); // R1

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step && count == LAST) |=> count == '0); // R6

endmodule

// File: rtl/edge_sel_counter.sv
module edge_sel_counter
  import edge_cnt_pkg::*;
#(
  parameter count_base_e BASE        = BASE_BIN,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mclr,
  input  logic             cnt_pulse,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] sync_in;
  logic             clr_s;
  logic             pulse_s;
  logic             en_s;
  logic             step;

  assign raw_in = {mclr, cnt_en, cnt_pulse};

  ecnt_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_in),
    .q   (sync_in)
  );

  assign pulse_s = sync_in[0];
  assign en_s    = sync_in[1];
  assign clr_s   = sync_in[2];

  ecnt_edge_qual u_qual (
    .clk     (clk),
    .rst     (clr_s),
    .pulse_s (pulse_s),
    .en_s    (en_s),
    .step    (step)
  );

  ecnt_core #(.BASE(BASE)) u_core (
    .clk   (clk),
    .rst   (clr_s),
    .step  (step),
    .count (count)
  );

  AST_ONE_STEP_PER_CYCLE: assert property (@(posedge clk) disable iff (clr_s)
    step |=> (count == $past(count) + 1'b1) || (count == '0)); // R8

endmodule

// File: tb/edge_sel_counter_bench.sv
module edge_sel_counter_bench;
  import edge_cnt_pkg::*;

  logic clk = 1'b0;
  logic mclr = 1'b1;
  logic p1 = 1'b0, e1 = 1'b1;
  logic pd = 1'b0, ed = 1'b1;
  logic [3:0] q1, q2, qd;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_sel_counter #(.BASE(BASE_BIN)) u_edge_sel_counter (
    .clk(clk), .mclr(mclr), .cnt_pulse(p1), .cnt_en(e1), .count(q1));

  edge_sel_counter #(.BASE(BASE_BIN)) u_stage2 (
    .clk(clk), .mclr(mclr), .cnt_pulse(1'b0), .cnt_en(q1[3]), .count(q2));

  edge_sel_counter #(.BASE(BASE_DEC)) u_dec (
    .clk(clk), .mclr(mclr), .cnt_pulse(pd), .cnt_en(ed), .count(qd));

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    settle(6);
    check(q1, 0, "R5 reset state");
    check(qd, 0, "R5 reset state dec");
    mclr = 1'b0;
    settle(5);
    check(q1, 0, "R5 release no count");

    p1 = 1'b1; settle(5); check(q1, 1, "R1 pulse rise en high");
    p1 = 1'b0; settle(5); check(q1, 1, "R3 pulse fall");
    e1 = 1'b0; settle(5); check(q1, 2, "R2 en fall pulse low");
    e1 = 1'b1; settle(5); check(q1, 2, "R3 en rise");
    p1 = 1'b1; settle(5); check(q1, 3, "R1 pulse rise again");
    e1 = 1'b0; settle(5); check(q1, 3, "R3 en fall pulse high");
    p1 = 1'b0; settle(5); check(q1, 3, "R3 pulse fall en low");
    p1 = 1'b1; settle(5); check(q1, 3, "R3 pulse rise en low");
    p1 = 1'b0; settle(5);
    e1 = 1'b1; settle(5); check(q1, 3, "R3 en rise pulse low");
    settle(40);            check(q1, 3, "R4 steady inputs");

    // both qualifying edges in the same sampled cycle
    p1 = 1'b1; e1 = 1'b0; settle(5); check(q1, 4, "R8 simultaneous edges");
    p1 = 1'b0; settle(5);
    e1 = 1'b1; settle(5); check(q1, 4, "R3 restore inputs");

    // clear overrides counting edges
    mclr = 1'b1; settle(5);
    p1 = 1'b1; settle(5); check(q1, 0, "R5 clear overrides rise");
    p1 = 1'b0; settle(5);
    e1 = 1'b0; settle(5); check(q1, 0, "R5 clear overrides en fall");
    e1 = 1'b1; settle(5);
    mclr = 1'b0; settle(5); check(q1, 0, "R5 after release");

    // binary sweep across the wrap point
    for (int k = 1; k <= 20; k++) begin
      p1 = 1'b1; settle(5);
      check(q1, k % 16, "R6 binary sweep");
      p1 = 1'b0; settle(5);
    end

    // decimal sweep, mixing both counting edges
    for (int k = 1; k <= 25; k++) begin
      if (k % 2 == 1) begin
        pd = 1'b1; settle(5);
        check(qd, k % 10, "R7 decimal via pulse");
        pd = 1'b0; settle(5);
      end else begin
        ed = 1'b0; settle(5);
        check(qd, k % 10, "R7 decimal via enable");
        ed = 1'b1; settle(5);
      end
    end

    // two-stage cascade through 255 and back to 0
    mclr = 1'b1; settle(6);
    mclr = 1'b0; settle(5);
    check({q2, q1}, 0, "R9 cascade start");
    for (int k = 1; k <= 260; k++) begin
      p1 = 1'b1; settle(9);
      check({q2, q1}, k % 256, "R9 cascade count");
      p1 = 1'b0; settle(5);
    end

    done = 1'b1;
    summary();
  end

endmodule